// File: doc/BRIEF.md
# Wide-to-Narrow Access Splitter with Lane Swapping

This block connects a 32-bit host register port to a 16-bit peripheral bus. Each host access arrives as a one-cycle request together with a slot number. The block turns that access into one or two 16-bit peripheral cycles. A full 32-bit access, meaning all four byte enables are set, becomes an ordered pair of cycles. An 8-bit or 16-bit access becomes a single cycle. When the access finishes, the block raises a one-cycle completion strobe. For reads, that strobe comes with the returned 32-bit word.

Every slot has two configuration bits of its own, a byte-swap bit and a word-swap bit. The block samples both bits for the addressed slot when it accepts the access. Byte swap changes which data lanes carry which bytes. Word swap changes which host half-word goes to which peripheral half-word address, and so it also changes the order of the two cycles. A programmable wait limit bounds every peripheral cycle. A cycle that is not acknowledged within that limit ends the whole access with a bus-error flag.

Top module: `hbus_split16`

## Requirements
- R1: With both swap bits clear, a 32-bit access runs two cycles. The first cycle carries host bits 15..0 at half-word offset 0 (per_addr bit 1 = 0). The second carries bits 31..16 at offset 2 (per_addr bit 1 = 1). Both cycles have per_be = 2'b11.
- R2: For an 8-bit or 16-bit access with byte swap set, the two bytes of the transferred half-word exchange places. The two peripheral byte enables exchange places the same way.
- R3: For a 32-bit access with byte swap set, the host word is byte-reversed before the split. Host bits 31..24 go to 7..0, 23..16 to 15..8, 15..8 to 23..16, and 7..0 to 31..24. Reads apply the same reversal in the other direction.
- R4: Word swap inverts per_addr bit 1 for every cycle. A 32-bit access therefore sends the low half first to offset 2 and then the high half to offset 0. A narrow access goes to offset (host address bit 1) XOR 1.
- R5: The swap bits used for an access are those of the slot given by host_slot when the access is accepted. per_slot carries that slot number throughout the access.
- R6: An access whose byte enables are not all set produces exactly one peripheral cycle. That cycle uses the host half selected by host address bit 1, and only that half's two byte enables (bits 1..0 for half 0, bits 3..2 for half 1). Read data is returned in that host half, and the other half reads zero.
- R7: A 32-bit read completes only after both peripheral cycles have been acknowledged. The first acknowledged half-word forms bits 15..0 and the second forms bits 31..16, before any byte reversal.
- R8: per_req rises one cycle after acceptance. It holds address and data stable until the cycle is acknowledged or times out. It drops for exactly one cycle between the two cycles of a 32-bit access.
- R9: host_done is a one-cycle pulse. It comes one cycle after the edge that samples the final acknowledge. Writes return zero data.
- R10: An acknowledge is taken in any of the first cfg_timeout+1 cycles of a request. If none arrives, the access ends with host_berr set and host_rdata all ones, and no further cycle is issued.
- R11: host_req is ignored while an access is in progress. It starts no peripheral cycle.
- R12: After reset, per_req, host_done and host_berr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | One-cycle access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W-1 (11) | Byte address bits ADDR_W-1..1 |
| host_be | input | 4 | Byte enables; 4'hF = 32-bit access |
| host_wdata | input | 32 | Write data |
| host_slot | input | SLOT_W (3) | Target slot |
| host_done | output | 1 | Completion pulse |
| host_rdata | output | 32 | Read result, valid with host_done |
| host_berr | output | 1 | Bus error, valid with host_done |
| cfg_bswap | input | NUM_SLOTS (5) | Byte-swap bit per slot |
| cfg_wswap | input | NUM_SLOTS (5) | Word-swap bit per slot |
| cfg_timeout | input | TO_W (8) | Wait limit per peripheral cycle |
| per_req | output | 1 | Peripheral cycle request |
| per_we | output | 1 | Peripheral write |
| per_addr | output | ADDR_W-1 (11) | Half-word address, bits ADDR_W-1..1 |
| per_be | output | 2 | Peripheral byte enables |
| per_wdata | output | 16 | Peripheral write data |
| per_slot | output | SLOT_W (3) | Slot of the current access |
| per_rdata | input | 16 | Peripheral read data |
| per_ack | input | 1 | Peripheral acknowledge |

## Verification
per_req becomes visible one cycle after the request edge. A gap of exactly one idle cycle separates the two halves of a 32-bit access. host_done follows one cycle after the edge that samples the final acknowledge. The bench samples on falling edges and checks each of these points at exactly that count, not by waiting for it. For a starved cycle the bench counts how many falling edges per_req stays high and expects cfg_timeout+1. In the cycle right after that it expects the error completion. Acknowledge delays are drawn at random up to and including the limit, so the last cycle that can still accept an acknowledge is exercised.

// File: rtl/hbus_split16_pkg.sv
package hbus_split16_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYC  = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } split_state_e;

  function automatic logic [31:0] rev_bytes32(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [15:0] swap_bytes16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

endpackage

// File: rtl/hbus_split16_lanes.sv
module hbus_split16_lanes
  import hbus_split16_pkg::*;
(
  input  logic        wide,
  input  logic        half_sel,
  input  logic        bswap,
  input  logic        wswap,
  input  logic        idx,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  input  logic [15:0] rd_first,
  input  logic [15:0] rd_last,
  output logic        off,
  output logic [15:0] wd16,
  output logic [1:0]  be2,
  output logic [31:0] rd32
);

  logic [31:0] w_t;
  logic [31:0] r_t;
  logic [15:0] n_d;
  logic [15:0] r_n;
  logic [1:0]  n_b;

  always_comb begin
    w_t = bswap ? rev_bytes32(wdata) : wdata;
    n_d = half_sel ? wdata[31:16] : wdata[15:0];
    n_b = half_sel ? be[3:2] : be[1:0];
    r_t = {rd_last, rd_first};
    r_n = bswap ? swap_bytes16(rd_last) : rd_last;
    if (wide) begin
      off  = idx ^ wswap;
      wd16 = idx ? w_t[31:16] : w_t[15:0];
      be2  = 2'b11;
      rd32 = bswap ? rev_bytes32(r_t) : r_t;
    end else begin
      off  = half_sel ^ wswap;
      wd16 = bswap ? swap_bytes16(n_d) : n_d;
      be2  = bswap ? {n_b[0], n_b[1]} : n_b;
      rd32 = half_sel ? {r_n, 16'h0000} : {16'h0000, r_n};
    end
  end

endmodule

// File: rtl/hbus_split16_wait.sv
module hbus_split16_wait #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [TO_W-1:0] limit,
  output logic            expired
);

  logic [TO_W-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (!expired)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: the wait count never passes the programmed limit
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit));

endmodule

// File: rtl/hbus_split16.sv
module hbus_split16
  import hbus_split16_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int SLOT_W    = $clog2(NUM_SLOTS),
  parameter int ADDR_W    = 12,
  parameter int TO_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:1] host_addr,
  input  logic [3:0]        host_be,
  input  logic [31:0]       host_wdata,
  input  logic [SLOT_W-1:0] host_slot,
  output logic              host_done,
  output logic [31:0]       host_rdata,
  output logic              host_berr,
  input  logic [NUM_SLOTS-1:0] cfg_bswap,
  input  logic [NUM_SLOTS-1:0] cfg_wswap,
  input  logic [TO_W-1:0]   cfg_timeout,
  output logic              per_req,
  output logic              per_we,
  output logic [ADDR_W-1:1] per_addr,
  output logic [1:0]        per_be,
  output logic [15:0]       per_wdata,
  output logic [SLOT_W-1:0] per_slot,
  input  logic [15:0]       per_rdata,
  input  logic              per_ack
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  split_state_e state_q, state_d;
  logic              idx_q, idx_d;
  logic [ADDR_W-1:2] addr_hi_q;
  logic              half_q, we_q, wide_q, bsw_q, wsw_q, berr_q;
  logic [3:0]        be_q;
  logic [31:0]       wdata_q, rdata_q;
  logic [15:0]       first_q;
  logic [SLOT_W-1:0] slot_q;

  logic        in_cyc, last_cyc, tmo, cap_en, first_en, fin_en;
  logic        lane_off;
  logic [31:0] lane_rd;

  assign in_cyc   = (state_q == ST_CYC);
  assign last_cyc = !wide_q || idx_q;
  assign cap_en   = (state_q == ST_IDLE) && host_req;
  assign first_en = in_cyc && per_ack && !last_cyc;
  assign fin_en   = in_cyc && (per_ack ? last_cyc : tmo);

  hbus_split16_wait #(.TO_W(TO_W)) u_wait (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .run     (in_cyc),
    .limit   (cfg_timeout),
    .expired (tmo)
  );

  hbus_split16_lanes u_lanes (
    .wide     (wide_q),
    .half_sel (half_q),
    .bswap    (bsw_q),
    .wswap    (wsw_q),
    .idx      (idx_q),
    .wdata    (wdata_q),
    .be       (be_q),
    .rd_first (first_q),
    .rd_last  (per_rdata),
    .off      (lane_off),
    .wd16     (per_wdata),
    .be2      (per_be),
    .rd32     (lane_rd)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      ST_IDLE: if (host_req) begin
        state_d = ST_CYC;
        idx_d   = 1'b0;
      end
      ST_CYC: begin
        if (per_ack) begin
          if (last_cyc) state_d = ST_DONE;
          else begin
            state_d = ST_GAP;
            idx_d   = 1'b1;
          end
        end else if (tmo) begin
          state_d = ST_DONE;
        end
      end
      ST_GAP:  state_d = ST_CYC;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_IDLE;
      idx_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      addr_hi_q <= '0;
      half_q    <= 1'b0;
      we_q      <= 1'b0;
      be_q      <= '0;
      wide_q    <= 1'b0;
      wdata_q   <= '0;
      slot_q    <= '0;
      bsw_q     <= 1'b0;
      wsw_q     <= 1'b0;
    end else if (cap_en) begin
      addr_hi_q <= host_addr[ADDR_W-1:2];
      half_q    <= host_addr[1];
      we_q      <= host_we;
      be_q      <= host_be;
      wide_q    <= (host_be == 4'hF);
      wdata_q   <= host_wdata;
      slot_q    <= host_slot;
      bsw_q     <= cfg_bswap[host_slot];
      wsw_q     <= cfg_wswap[host_slot];
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)      first_q <= '0;
    else if (first_en) first_q <= per_rdata;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      rdata_q <= '0;
      berr_q  <= 1'b0;
    end else if (fin_en) begin
      rdata_q <= per_ack ? (we_q ? 32'h0 : lane_rd) : 32'hFFFF_FFFF;
      berr_q  <= !per_ack;
    end
  end

  assign per_req    = in_cyc;
  assign per_we     = we_q;
  assign per_addr   = {addr_hi_q, lane_off};
  assign per_slot   = slot_q;
  assign host_done  = (state_q == ST_DONE);
  assign host_berr  = host_done && berr_q;
  assign host_rdata = rdata_q;

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    host_done |=> !host_done);

  // R10: a bus error always returns all ones
  p_berr_ones_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    host_berr |-> (host_rdata == 32'hFFFF_FFFF));

  // R8: an unanswered request holds and keeps its address and data
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (per_req && !per_ack && !tmo) |=> (per_req && $stable(per_addr) && $stable(per_wdata)));

  // R7: after the first half of a 32-bit access, a gap and no completion
  p_wide_gap_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (per_req && per_ack && wide_q && !idx_q) |=> (!per_req && !host_done));

  // R6: a narrow access completes right after its single acknowledge
  p_narrow_one_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (per_req && per_ack && !wide_q) |=> (host_done && !host_berr));

  // R11: a request during the completion cycle starts nothing
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (host_done && host_req) |=> !per_req);

endmodule

// File: tb/hbus_split16_test.sv
module hbus_split16_test;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 5;
  localparam int SW = 3;
  localparam int AW = 12;
  localparam int TW = 8;

  logic          clk;
  logic          rst_n;
  logic          host_req, host_we;
  logic [AW-1:1] host_addr;
  logic [3:0]    host_be;
  logic [31:0]   host_wdata;
  logic [SW-1:0] host_slot;
  logic          host_done, host_berr;
  logic [31:0]   host_rdata;
  logic [NS-1:0] cfg_bswap, cfg_wswap;
  logic [TW-1:0] cfg_timeout;
  logic          per_req, per_we, per_ack;
  logic [AW-1:1] per_addr;
  logic [1:0]    per_be;
  logic [15:0]   per_wdata, per_rdata;
  logic [SW-1:0] per_slot;

  int n_chk;
  int n_bad;

  hbus_split16 uut (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_be(host_be), .host_wdata(host_wdata), .host_slot(host_slot),
    .host_done(host_done), .host_rdata(host_rdata), .host_berr(host_berr),
    .cfg_bswap(cfg_bswap), .cfg_wswap(cfg_wswap), .cfg_timeout(cfg_timeout),
    .per_req(per_req), .per_we(per_we), .per_addr(per_addr), .per_be(per_be),
    .per_wdata(per_wdata), .per_slot(per_slot), .per_rdata(per_rdata),
    .per_ack(per_ack)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] flip16(input logic [15:0] v);
    logic [15:0] r;
    r[15:8] = v[7:0];
    r[7:0]  = v[15:8];
    return r;
  endfunction

  function automatic logic [31:0] flip32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[8*i +: 8] = v[8*(3-i) +: 8];
    return r;
  endfunction

  // expected content of peripheral cycle k
  task automatic exp_cycle(input bit wide, input bit h, input bit bs, input bit ws, input int k,
                           input logic [31:0] wd, input logic [3:0] be,
                           output bit off, output logic [15:0] d, output logic [1:0] b);
    logic [31:0] t;
    if (wide) begin
      t   = bs ? flip32(wd) : wd;        // R3
      d   = (k == 0) ? t[15:0] : t[31:16]; // R1
      off = (k == 1) ^ ws;                // R4
      b   = 2'b11;
    end else begin
      d   = h ? wd[31:16] : wd[15:0];     // R6
      b   = h ? be[3:2] : be[1:0];
      if (bs) begin                       // R2
        d = flip16(d);
        b = {b[0], b[1]};
      end
      off = h ^ ws;
    end
  endtask

  function automatic logic [31:0] exp_read(input bit wide, input bit h, input bit bs,
                                           input logic [15:0] r0, input logic [15:0] r1);
    logic [15:0] n;
    if (wide) return bs ? flip32({r1, r0}) : {r1, r0}; // R7
    n = bs ? flip16(r0) : r0;
    return h ? {n, 16'h0} : {16'h0, n};
  endfunction

  task automatic access(input int slot, input logic [AW-1:1] addr, input bit we,
                        input logic [3:0] be, input logic [31:0] wd,
                        input logic [15:0] r0, input logic [15:0] r1,
                        input int dly, input bit starve, input bit poke);
    bit wide, bs, ws, off;
    logic [15:0] ed;
    logic [1:0] eb;
    int ncyc;
    wide = (be == 4'hF);
    bs = cfg_bswap[slot];
    ws = cfg_wswap[slot];
    ncyc = wide ? 2 : 1;
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = addr; host_be = be;
    host_wdata = wd; host_slot = SW'(slot);
    @(negedge clk);
    host_req = 1'b0;
    // R5: slot settings captured at acceptance, changing them now has no effect
    cfg_bswap = ~cfg_bswap; cfg_wswap = ~cfg_wswap;
    for (int k = 0; k < ncyc; k++) begin
      if (k == 1) begin
        check(per_req == 1'b0, "R8 gap between halves", {31'b0, per_req}, 0);
        @(negedge clk);
      end
      check(per_req == 1'b1, "R8 request raised", {31'b0, per_req}, 1);
      exp_cycle(wide, addr[1], bs, ws, k, wd, be, off, ed, eb);
      check(per_addr == {addr[AW-1:2], off}, "R1 R4 half-word address", 32'(per_addr), 32'({addr[AW-1:2], off}));
      check(per_be == eb, "R2 R6 byte enables", 32'(per_be), 32'(eb));
      check(per_we == we, "R1 direction", 32'(per_we), 32'(we));
      check(per_slot == SW'(slot), "R5 slot", 32'(per_slot), 32'(slot));
      if (we) check(per_wdata == ed, "R1 R2 R3 write lanes", 32'(per_wdata), 32'(ed));
      if (starve && k == 0) begin
        int n = 0;
        while (per_req && n < 600) begin
          n++;
          @(negedge clk);
        end
        check(n == int'(cfg_timeout) + 1, "R10 request cycles before abort", n, int'(cfg_timeout) + 1);
        check(host_done && host_berr, "R10 error completion", {host_done, host_berr}, 2'b11);
        check(host_rdata == 32'hFFFF_FFFF, "R10 error data", host_rdata, 32'hFFFF_FFFF);
        @(negedge clk);
        check(!per_req && !host_done, "R10 no further cycle", {per_req, host_done}, 0);
        cfg_bswap = ~cfg_bswap; cfg_wswap = ~cfg_wswap;
        return;
      end
      for (int j = 0; j < dly; j++) begin
        if (poke && k == 0 && j == 0) begin
          host_req = 1'b1; host_addr = ~addr; host_be = 4'h1;
        end
        @(negedge clk);
        host_req = 1'b0;
        check(per_req == 1'b1, "R8 request held", {31'b0, per_req}, 1);
      end
      per_ack = 1'b1;
      per_rdata = (k == 0) ? r0 : r1;
      @(negedge clk);
      per_ack = 1'b0;
      per_rdata = 16'hDEAD;
      if (k == ncyc - 1) begin
        check(host_done == 1'b1, "R9 done one cycle after final ack", {31'b0, host_done}, 1);
        check(host_berr == 1'b0, "R9 no error", {31'b0, host_berr}, 0);
        if (!we) check(host_rdata == exp_read(wide, addr[1], bs, r0, r1), "R6 R7 read assembly",
                       host_rdata, exp_read(wide, addr[1], bs, r0, r1));
        else check(host_rdata == 32'h0, "R9 write returns zero", host_rdata, 0);
      end else begin
        check(host_done == 1'b0, "R7 no completion after first half", {31'b0, host_done}, 0);
      end
    end
    @(negedge clk);
    check(host_done == 1'b0, "R9 done is a pulse", {31'b0, host_done}, 0);
    if (poke) begin
      for (int j = 0; j < 3; j++) begin
        check(per_req == 1'b0, "R11 busy request ignored", {31'b0, per_req}, 0);
        @(negedge clk);
      end
    end
    cfg_bswap = ~cfg_bswap; cfg_wswap = ~cfg_wswap;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] be;
    logic [AW-1:1] a;
    n_chk = 0; n_bad = 0;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_addr = '0; host_be = '0;
    host_wdata = '0; host_slot = '0; cfg_bswap = '0; cfg_wswap = '0;
    cfg_timeout = 8'd4; per_ack = 1'b0; per_rdata = '0;
    repeat (3) @(negedge clk);
    check(!per_req && !host_done && !host_berr, "R12 reset outputs", {per_req, host_done, host_berr}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!per_req && !host_done, "R12 idle after reset", {per_req, host_done}, 0);

    // directed: straight through, all swap combinations on distinct slots
    cfg_bswap = 5'b01010; cfg_wswap = 5'b01100;
    access(0, 11'h040, 1'b1, 4'hF, 32'hA1B2C3D4, 0, 0, 0, 0, 0); // R1
    access(1, 11'h041, 1'b1, 4'hF, 32'h11223344, 0, 0, 1, 0, 0); // R3
    access(2, 11'h042, 1'b1, 4'hF, 32'h55667788, 0, 0, 2, 0, 0); // R4
    access(3, 11'h043, 1'b0, 4'hF, 0, 16'hBEEF, 16'hCAFE, 1, 0, 0); // R3 R4 R7
    access(1, 11'h003, 1'b1, 4'b0100, 32'h00AB0000, 0, 0, 0, 0, 0); // R2 R6
    access(2, 11'h002, 1'b0, 4'b0011, 0, 16'h1357, 0, 0, 0, 0);    // R4 R6
    // boundary: ack on the last allowed cycle, then starvation
    cfg_timeout = 8'd3;
    access(0, 11'h010, 1'b0, 4'hF, 0, 16'h0F0F, 16'hF0F0, 3, 0, 0); // R10
    access(4, 11'h010, 1'b0, 4'hF, 0, 0, 0, 0, 1, 0);               // R10
    access(0, 11'h011, 1'b1, 4'b1000, 32'h9A000000, 0, 0, 0, 1, 0); // R10
    cfg_timeout = 8'd0;
    access(3, 11'h020, 1'b1, 4'hF, 32'h01020304, 0, 0, 0, 0, 0);
    access(3, 11'h020, 1'b1, 4'hF, 32'h01020304, 0, 0, 0, 1, 0);
    cfg_timeout = 8'd5;
    access(2, 11'h030, 1'b1, 4'hF, 32'hFEEDF00D, 0, 0, 3, 0, 1);    // R11

    // constrained random
    for (int i = 0; i < 400; i++) begin
      int slot, dly;
      bit we, starve;
      logic [31:0] wd;
      cfg_bswap = NS'($urandom); cfg_wswap = NS'($urandom);
      cfg_timeout = TW'($urandom_range(0, 12));
      slot = $urandom_range(0, NS - 1);
      a = AW'($urandom) >> 1;
      we = $urandom_range(0, 1) == 1;
      wd = $urandom;
      case ($urandom_range(0, 3))
        0, 1: be = 4'hF;
        2: be = a[1] ? 4'b1100 : 4'b0011;
        default: be = a[1] ? (4'b0100 << $urandom_range(0, 1)) : (4'b0001 << $urandom_range(0, 1));
      endcase
      dly = $urandom_range(0, int'(cfg_timeout));
      starve = $urandom_range(0, 15) == 0;
      access(slot, a, we, be, wd, 16'($urandom), 16'($urandom), dly, starve, 1'b0);
    end

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule